// File: doc/BRIEF.md
# Load Effective-Address Stage with Latency Classing

This block is the address stage in front of a data cache on the load path. Each request carries a base value, an optional index register number and value, a two-bit scale code, a signed 32-bit displacement and a tag. The block computes the 64-bit effective address, base plus index times scale plus displacement, with wrap-around.

It also sorts every load into a fast class or a slow class. A load with no index and a small non-negative displacement takes the fast path, which is one cycle shorter than the slow path. A load whose index register is known to hold zero also takes the fast path. That knowledge comes from a 16-entry scoreboard, which is updated on every register write. An entry is set only when the write is a recognised zeroing idiom, such as a register XORed with itself.

Results leave in the order the requests were accepted. A fast load that would overtake an older slow load is held back by one slot, but it still reports the fast class. The stage takes one request per cycle whatever the class. When the consumer applies backpressure, the whole pipeline freezes.

Top module: `load_agen`

## Requirements
- R1: `out_addr` equals `in_base + in_index_val*S + sext(in_disp)` modulo 2^64. S is 1, 2, 4 or 8 for scale codes 0, 1, 2 and 3. The index term is zero when `in_has_index` is 0, whatever `in_index_val` holds.
- R2: `out_slow` is 0 (fast) only when `in_disp`, read as a signed value, lies in 0..2047 and either `in_has_index` is 0 or the index register is flagged known-zero. Every other case gives 1 (slow), including negative displacements and displacements above 2047.
- R3: With `out_ready` held high and no older result in the way, a result is presented 4 cycles after the acceptance cycle when `out_slow` is 0, and 5 cycles after it when `out_slow` is 1.
- R4: Results come out in acceptance order, each with its own `in_tag`. A fast load accepted one cycle after a slow load comes out in the cycle after that slow load, so its latency is 5, and it still reports `out_slow` = 0. In general a result's cycle is the later of its class latency and one cycle after the previous result.
- R5: Whenever the output is not stalled (`out_valid` low or `out_ready` high), `in_ready` is 1, so one request per cycle is accepted for every class.
- R6: The scoreboard resets to all not-zero. A write with `wr_zero_idiom` = 1 sets the entry for `wr_reg`. A write with `wr_zero_idiom` = 0 clears it, even when the value written is zero.
- R7: When a register write and a request that names the same index register fall in the same cycle, the class is decided by the flag as it stood before that write.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the output holds stable. No accepted request is lost or duplicated.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high |
| in_base | input | 64 | Base register value |
| in_has_index | input | 1 | Index register is used |
| in_index_reg | input | 4 | Index register number (scoreboard lookup) |
| in_index_val | input | 64 | Index register value |
| in_scale | input | 2 | Scale code: 0→×1, 1→×2, 2→×4, 3→×8 |
| in_disp | input | 32 | Signed displacement |
| in_tag | input | 4 | Request tag, returned with the result |
| wr_en | input | 1 | Register write this cycle |
| wr_reg | input | 4 | Written register number |
| wr_zero_idiom | input | 1 | Write is a zeroing idiom |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts result |
| out_addr | output | 64 | Effective address |
| out_tag | output | 4 | Tag of the result |
| out_slow | output | 1 | 0 = 4-cycle class, 1 = 5-cycle class |

## Verification
A stale or wrongly written scoreboard entry shows up as a wrong `out_slow` on the very next load that names that register. A slot that is dropped, duplicated or inserted in the wrong place shows up within five cycles as a wrong tag, an address that belongs to another request, or an output cycle that breaks the later-of-latency-and-predecessor rule. A broken stall path shows up in the first cycle of backpressure, as a moving output or an accepted request. The sweep covers every scale, index and flag combination against boundary displacements, followed by randomized traffic with writes that collide with requests.

// File: rtl/lagen_pkg.sv
// Shared types for the load effective-address stage.
// Assumes: a one-bit latency class; scale is a 2-bit shift amount.
package lagen_pkg;

    // Latency class reported with every result
    typedef enum logic {
        CLS_FAST = 1'b0,
        CLS_SLOW = 1'b1
    } lat_cls_e;

    // Scale code as carried on the request
    typedef enum logic [1:0] {
        SC_X1 = 2'd0,
        SC_X2 = 2'd1,
        SC_X4 = 2'd2,
        SC_X8 = 2'd3
    } scale_e;

endpackage

// File: rtl/lagen_zero_board.sv
// Known-zero scoreboard: one flag per architectural register.
// A write sets its flag only when marked as a zeroing idiom; any other
// write clears it. The read port is combinational from the flops, so a
// same-cycle write is not visible to the read (old value wins).
// Assumes: NUM_REGS is a power of two equal to 2**REG_W.
module lagen_zero_board #(
    parameter int NUM_REGS = 16,
    parameter int REG_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_reg,
    input  logic             wr_zero,
    input  logic [REG_W-1:0] rd_reg,
    output logic             rd_zero
);

    logic [NUM_REGS-1:0] zflag_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        // Update one flag: reset to not-zero, then follow the idiom marker
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                zflag_q[g] <= 1'b0;
            end else if (wr_en && (wr_reg == REG_W'(g))) begin
                zflag_q[g] <= wr_zero;
            end
        end
    end

    // Read the pre-write flag for the requested register
    always_comb begin
        rd_zero = zflag_q[rd_reg];
    end

endmodule

// File: rtl/lagen_classify.sv
// Effective-address adder and latency classifier (combinational).
// Computes base + index*scale + sign-extended displacement modulo 2**ADDR_W,
// and decides fast/slow: fast needs 0 <= disp <= FAST_LIMIT and either no
// index or an index flagged known-zero.
// Assumes: DISP_W < ADDR_W; FAST_LIMIT fits in DISP_W-1 bits.
module lagen_classify
    import lagen_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int DISP_W     = 32,
    parameter int FAST_LIMIT = 2047
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              has_index,
    input  logic [ADDR_W-1:0] index_val,
    input  logic [1:0]        scale,
    input  logic [DISP_W-1:0] disp,
    input  logic              index_zero,
    output logic [ADDR_W-1:0] ea,
    output lat_cls_e          cls
);

    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] scaled_idx;
    logic [ADDR_W-1:0] disp_ext;
    logic              disp_in_window;
    logic              index_waived;

    // Scale the index by a left shift chosen from the 2-bit code
    always_comb begin
        unique case (scale_e'(scale))
            SC_X1:   scaled_idx = index_val;
            SC_X2:   scaled_idx = {index_val[ADDR_W-2:0], 1'b0};
            SC_X4:   scaled_idx = {index_val[ADDR_W-3:0], 2'b00};
            default: scaled_idx = {index_val[ADDR_W-4:0], 3'b000};
        endcase
        if (!has_index) begin
            scaled_idx = '0;
        end
    end

    // Sign-extend the displacement and form the wrapping three-way sum
    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        ea       = base + scaled_idx + disp_ext;
    end

    // Decide the latency class from displacement window and index state
    always_comb begin
        disp_in_window = !disp[DISP_W-1] && (disp <= DISP_W'(FAST_LIMIT));
        index_waived   = !has_index || index_zero;
        cls            = (disp_in_window && index_waived) ? CLS_FAST : CLS_SLOW;
    end

endmodule

// File: rtl/lagen_order_pipe.sv
// In-order result pipeline with a skip entry for the fast class.
// LAT_SLOW slots shift toward the output each un-stalled cycle. Slow
// entries enter slot 0; fast entries enter slot LAT_SLOW-LAT_FAST, but
// only if every slot below it is empty, otherwise slot 0 so nothing older
// is overtaken. The whole pipe freezes while the head is valid and not
// taken.
// Assumes: 1 <= LAT_FAST < LAT_SLOW.
module lagen_order_pipe
    import lagen_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int TAG_W    = 4,
    parameter int LAT_FAST = 4,
    parameter int LAT_SLOW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [TAG_W-1:0]  push_tag,
    input  lat_cls_e          push_cls,
    input  logic              pop_ready,
    output logic              can_push,
    output logic              head_valid,
    output logic [ADDR_W-1:0] head_addr,
    output logic [TAG_W-1:0]  head_tag,
    output lat_cls_e          head_cls
);

    localparam int DEPTH     = LAT_SLOW;
    localparam int FAST_SLOT = LAT_SLOW - LAT_FAST;
    localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [TAG_W-1:0]  tag;
        lat_cls_e          cls;
    } slot_t;

    slot_t            slot_q [DEPTH];
    slot_t            slot_d [DEPTH];
    slot_t            new_slot;
    logic             advance;
    logic             lower_busy;
    logic [IDX_W-1:0] entry_idx;

    // Freeze everything while the head waits for the consumer
    always_comb begin
        advance  = !(slot_q[DEPTH-1].vld && !pop_ready);
        can_push = advance;
    end

    // Check whether any older entry sits below the fast entry slot
    always_comb begin
        lower_busy = 1'b0;
        for (int j = 0; j < FAST_SLOT; j++) begin
            lower_busy = lower_busy | slot_q[j].vld;
        end
    end

    // Choose where the new entry goes and assemble it
    always_comb begin
        entry_idx     = ((push_cls == CLS_FAST) && !lower_busy) ? IDX_W'(FAST_SLOT) : '0;
        new_slot.vld  = 1'b1;
        new_slot.addr = push_addr;
        new_slot.tag  = push_tag;
        new_slot.cls  = push_cls;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_next
        if (i == 0) begin : g_first
            // First slot either takes the new entry or empties
            always_comb begin
                slot_d[i] = (push && (entry_idx == IDX_W'(i))) ? new_slot : '0;
            end
        end else begin : g_rest
            // Later slots take the new entry or shift from below
            always_comb begin
                slot_d[i] = (push && (entry_idx == IDX_W'(i))) ? new_slot : slot_q[i-1];
            end
        end
    end

    // Register all slots, advancing only when not stalled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                slot_q[k] <= '0;
            end
        end else if (advance) begin
            for (int k = 0; k < DEPTH; k++) begin
                slot_q[k] <= slot_d[k];
            end
        end
    end

    // Present the oldest slot at the output
    always_comb begin
        head_valid = slot_q[DEPTH-1].vld;
        head_addr  = slot_q[DEPTH-1].addr;
        head_tag   = slot_q[DEPTH-1].tag;
        head_cls   = slot_q[DEPTH-1].cls;
    end

endmodule

// File: rtl/load_agen.sv
// Load effective-address stage with a fast path for simple addressing.
// Accepts one request per cycle, computes the address at acceptance,
// classifies it using the known-zero scoreboard (pre-write value), and
// returns results in order after LAT_FAST or LAT_SLOW cycles.
// Assumes: the consumer may stall at any time; requests are independent.
module load_agen
    import lagen_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int DISP_W     = 32,
    parameter int TAG_W      = 4,
    parameter int NUM_REGS   = 16,
    parameter int LAT_FAST   = 4,
    parameter int LAT_SLOW   = 5,
    parameter int FAST_LIMIT = 2047,
    localparam int REG_W     = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_base,
    input  logic              in_has_index,
    input  logic [REG_W-1:0]  in_index_reg,
    input  logic [ADDR_W-1:0] in_index_val,
    input  logic [1:0]        in_scale,
    input  logic [DISP_W-1:0] in_disp,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_reg,
    input  logic              wr_zero_idiom,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [TAG_W-1:0]  out_tag,
    output logic              out_slow
);

    logic              idx_known_zero;
    logic [ADDR_W-1:0] req_ea;
    lat_cls_e          req_cls;
    lat_cls_e          head_cls;
    logic              can_push;
    logic              push;

    lagen_zero_board #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W)
    ) u_board (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_reg  (wr_reg),
        .wr_zero (wr_zero_idiom),
        .rd_reg  (in_index_reg),
        .rd_zero (idx_known_zero)
    );

    lagen_classify #(
        .ADDR_W     (ADDR_W),
        .DISP_W     (DISP_W),
        .FAST_LIMIT (FAST_LIMIT)
    ) u_class (
        .base       (in_base),
        .has_index  (in_has_index),
        .index_val  (in_index_val),
        .scale      (in_scale),
        .disp       (in_disp),
        .index_zero (idx_known_zero),
        .ea         (req_ea),
        .cls        (req_cls)
    );

    // Accept a request whenever the pipe can advance
    always_comb begin
        push     = in_valid && can_push;
        in_ready = can_push;
        out_slow = (head_cls == CLS_SLOW);
    end

    lagen_order_pipe #(
        .ADDR_W   (ADDR_W),
        .TAG_W    (TAG_W),
        .LAT_FAST (LAT_FAST),
        .LAT_SLOW (LAT_SLOW)
    ) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_addr  (req_ea),
        .push_tag   (in_tag),
        .push_cls   (req_cls),
        .pop_ready  (out_ready),
        .can_push   (can_push),
        .head_valid (out_valid),
        .head_addr  (out_addr),
        .head_tag   (out_tag),
        .head_cls   (head_cls)
    );

endmodule

// File: rtl/load_agen_chk.sv
// Property checker for load_agen, attached with bind below.
// Relates handshake ports over time and the internal class decision to
// the port history of register writes.
module load_agen_chk
    import lagen_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int DISP_W     = 32,
    parameter int TAG_W      = 4,
    parameter int REG_W      = 4,
    parameter int FAST_LIMIT = 2047
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_has_index,
    input logic [REG_W-1:0]  in_index_reg,
    input logic [DISP_W-1:0] in_disp,
    input logic              wr_en,
    input logic [REG_W-1:0]  wr_reg,
    input logic              wr_zero_idiom,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic [TAG_W-1:0]  out_tag,
    input logic              out_slow,
    input lat_cls_e          req_cls
);

    logic past_ok;
    logic disp_small;

    // Mark the cycles whose previous cycle was already out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    // Port-level view of the displacement window
    always_comb begin
        disp_small = !in_disp[DISP_W-1] && (in_disp <= DISP_W'(FAST_LIMIT));
    end

    // R8: a stalled result stays put
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                       && $stable(out_tag) && $stable(out_slow)));

    // R8: no acceptance while stalled
    a_r8_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R5: full throughput whenever the output is free
    a_r5_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || out_ready) |-> in_ready);

    // R2: out-of-window displacement is always slow
    a_r2_wide_disp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !disp_small) |-> (req_cls == CLS_SLOW));

    // R2: base plus small displacement is always fast
    a_r2_plain_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_has_index && disp_small) |-> (req_cls == CLS_FAST));

    // R6: a plain write last cycle leaves the index not-zero
    a_r6_plain_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && in_valid && in_has_index && $past(wr_en) && !$past(wr_zero_idiom)
         && ($past(wr_reg) == in_index_reg)) |-> (req_cls == CLS_SLOW));

    // R7: an idiom write last cycle waives the index, whatever is written now
    a_r7_idiom_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && in_valid && in_has_index && disp_small && $past(wr_en)
         && $past(wr_zero_idiom) && ($past(wr_reg) == in_index_reg))
        |-> (req_cls == CLS_FAST));

endmodule

bind load_agen load_agen_chk #(
    .ADDR_W     (ADDR_W),
    .DISP_W     (DISP_W),
    .TAG_W      (TAG_W),
    .REG_W      (REG_W),
    .FAST_LIMIT (FAST_LIMIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_has_index  (in_has_index),
    .in_index_reg  (in_index_reg),
    .in_disp       (in_disp),
    .wr_en         (wr_en),
    .wr_reg        (wr_reg),
    .wr_zero_idiom (wr_zero_idiom),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_addr      (out_addr),
    .out_tag       (out_tag),
    .out_slow      (out_slow),
    .req_cls       (req_cls)
);

// File: tb/tb_load_agen.sv
`timescale 1ns/1ps
// Self-checking bench: boundary sweep, directed ordering and collision
// cases, then randomized traffic with backpressure.
module tb_load_agen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [63:0] in_base;
    logic        in_has_index;
    logic [3:0]  in_index_reg;
    logic [63:0] in_index_val;
    logic [1:0]  in_scale;
    logic [31:0] in_disp;
    logic [3:0]  in_tag;
    logic        wr_en;
    logic [3:0]  wr_reg;
    logic        wr_zero_idiom;
    logic        out_valid;
    logic        out_ready;
    logic [63:0] out_addr;
    logic [3:0]  out_tag;
    logic        out_slow;

    always #2.5 clk = ~clk;

    load_agen dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_base(in_base), .in_has_index(in_has_index), .in_index_reg(in_index_reg),
        .in_index_val(in_index_val), .in_scale(in_scale), .in_disp(in_disp),
        .in_tag(in_tag), .wr_en(wr_en), .wr_reg(wr_reg), .wr_zero_idiom(wr_zero_idiom),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_tag(out_tag), .out_slow(out_slow)
    );

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    int wp     = 0;
    int rp     = 0;
    int last_exp = 0;
    bit lat_mode = 1'b0;
    bit done     = 1'b0;

    logic [63:0] e_addr [0:4095];
    logic [3:0]  e_tag  [0:4095];
    logic        e_slow [0:4095];
    int          e_cyc  [0:4095];
    bit          e_late [0:4095];
    bit          e_lat  [0:4095];
    bit          e_r7   [0:4095];
    bit          e_idx  [0:4095];
    bit          zmodel [0:15];

    bit          hold_pend = 1'b0;
    logic [63:0] hold_addr;
    logic [3:0]  hold_tag;
    logic [3:0]  tag_ctr = 4'd0;
    logic [31:0] rng = 32'h1234_5678;

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    function automatic logic [31:0] disp_pick(input int i);
        case (i)
            0: return 32'd0;
            1: return 32'd1;
            2: return 32'd2047;
            3: return 32'd2048;
            4: return 32'hFFFF_FFFF;
            5: return 32'h8000_0000;
            6: return 32'h7FFF_FFFF;
            default: return 32'd1000;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Evaluate this cycle's handshakes (inputs already applied, before the edge)
    task automatic eval_cycle();
        logic [63:0] mult;
        logic [63:0] ea;
        bit          dok;
        bit          slow;
        int          base_c;
        int          ec;
        if (hold_pend) begin
            chk(out_valid === 1'b1 && out_addr === hold_addr && out_tag === hold_tag,
                "R8", "held output", out_addr, hold_addr);
        end
        if (out_valid && !out_ready)
            chk(in_ready === 1'b0, "R8", "in_ready under stall", 64'(in_ready), 64'd0);
        else
            chk(in_ready === 1'b1, "R5", "in_ready when free", 64'(in_ready), 64'd1);
        hold_pend = out_valid && !out_ready;
        hold_addr = out_addr;
        hold_tag  = out_tag;
        if (out_valid && out_ready) begin
            if (rp == wp) begin
                chk(1'b0, "R8", "output with nothing outstanding", 64'(out_tag), 64'd0);
            end else begin
                chk(out_addr === e_addr[rp], "R1", "effective address", out_addr, e_addr[rp]);
                chk(out_tag === e_tag[rp], "R4", "result order tag", 64'(out_tag), 64'(e_tag[rp]));
                chk(out_slow === e_slow[rp],
                    e_r7[rp] ? "R7" : (e_idx[rp] ? "R6" : "R2"),
                    "latency class", 64'(out_slow), 64'(e_slow[rp]));
                if (e_lat[rp])
                    chk(cyc == e_cyc[rp], e_late[rp] ? "R4" : "R3", "output cycle",
                        64'(cyc), 64'(e_cyc[rp]));
                rp++;
            end
        end
        if (in_valid && in_ready) begin
            case (in_scale)
                2'd0: mult = 64'd1;
                2'd1: mult = 64'd2;
                2'd2: mult = 64'd4;
                default: mult = 64'd8;
            endcase
            ea = in_base + (in_has_index ? in_index_val * mult : 64'd0)
                 + {{32{in_disp[31]}}, in_disp};
            dok  = ($signed(in_disp) >= 0) && ($signed(in_disp) <= 2047);
            slow = !(dok && (!in_has_index || zmodel[in_index_reg]));
            base_c = cyc + (slow ? 5 : 4);
            ec = (base_c > last_exp + 1) ? base_c : last_exp + 1;
            last_exp = ec;
            e_addr[wp] = ea;
            e_tag[wp]  = in_tag;
            e_slow[wp] = slow;
            e_cyc[wp]  = ec;
            e_late[wp] = (ec != base_c);
            e_lat[wp]  = lat_mode;
            e_r7[wp]   = in_has_index && wr_en && (wr_reg == in_index_reg);
            e_idx[wp]  = in_has_index;
            wp++;
        end
        if (wr_en) zmodel[wr_reg] = wr_zero_idiom;
    endtask

    task automatic tick();
        #1;
        eval_cycle();
        @(negedge clk);
        cyc++;
    endtask

    task automatic set_req(input bit v, input logic [63:0] b, input bit h,
                           input logic [3:0] r, input logic [63:0] iv,
                           input logic [1:0] sc, input logic [31:0] d);
        in_valid     = v;
        in_base      = b;
        in_has_index = h;
        in_index_reg = r;
        in_index_val = iv;
        in_scale     = sc;
        in_disp      = d;
        in_tag       = tag_ctr;
        tag_ctr      = tag_ctr + 4'd1;
    endtask

    task automatic set_wr(input bit e, input logic [3:0] r, input bit z);
        wr_en = e;
        wr_reg = r;
        wr_zero_idiom = z;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        set_wr(1'b0, 4'd0, 1'b0);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R5 watchdog expired: actual=%0d expected=%0d", wp - rp, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 16; r++) zmodel[r] = 1'b0;
        rst_n = 1'b0;
        out_ready = 1'b1;
        set_req(1'b0, 64'd0, 1'b0, 4'd0, 64'd0, 2'd0, 32'd0);
        set_wr(1'b0, 4'd0, 1'b0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: reset state
        chk(out_valid === 1'b0, "R9", "out_valid after reset", 64'(out_valid), 64'd0);
        chk(in_ready === 1'b1, "R9", "in_ready after reset", 64'(in_ready), 64'd1);
        @(negedge clk);

        // R6: scoreboard setup: all idiom writes, then plain writes to odd regs
        for (int r = 0; r < 16; r++) begin
            set_wr(1'b1, 4'(r), 1'b1);
            tick();
        end
        for (int r = 1; r < 16; r += 2) begin
            set_wr(1'b1, 4'(r), 1'b0);
            tick();
        end
        set_wr(1'b0, 4'd0, 1'b0);

        // Sweep: scale x index use x known-zero x boundary displacements
        lat_mode = 1'b1;
        for (int sc = 0; sc < 4; sc++)
            for (int h = 0; h < 2; h++)
                for (int z = 0; z < 2; z++)
                    for (int di = 0; di < 8; di++) begin
                        logic [63:0] b;
                        logic [63:0] iv;
                        rng = nxt(rng); b = {rng, 32'h0};
                        rng = nxt(rng); b = b | 64'(rng);
                        rng = nxt(rng); iv = {rng, ~rng};
                        if (h == 1 && z == 1) iv = 64'd0;
                        set_req(1'b1, b, h[0], 4'(z == 1 ? 2 * (di % 8) : 2 * (di % 8) + 1),
                                iv, 2'(sc), disp_pick(di));
                        tick();
                    end
        idle(8);

        // Directed: isolated fast, isolated slow, slow then fast (R3, R4)
        last_exp = 0;
        set_req(1'b1, 64'h1000, 1'b0, 4'd0, 64'd0, 2'd0, 32'd16); tick(); idle(7);
        set_req(1'b1, 64'h2000, 1'b1, 4'd1, 64'd5, 2'd3, 32'd16); tick(); idle(7);
        set_req(1'b1, 64'h3000, 1'b0, 4'd0, 64'd0, 2'd0, 32'hFFFF_FFF0); tick();
        set_req(1'b1, 64'h4000, 1'b0, 4'd0, 64'd0, 2'd0, 32'd8); tick();
        set_req(1'b1, 64'h5000, 1'b0, 4'd0, 64'd0, 2'd0, 32'd8); tick();
        idle(8);

        // Directed R7: same-cycle writes to the index register use the old flag
        set_req(1'b1, 64'h6000, 1'b1, 4'd3, 64'd0, 2'd2, 32'd8);
        set_wr(1'b1, 4'd3, 1'b1); tick();
        set_req(1'b1, 64'h7000, 1'b1, 4'd3, 64'd0, 2'd2, 32'd8);
        set_wr(1'b1, 4'd3, 1'b0); tick();
        set_req(1'b1, 64'h8000, 1'b1, 4'd3, 64'd0, 2'd2, 32'd8);
        set_wr(1'b0, 4'd0, 1'b0); tick();
        idle(8);

        // Randomized traffic with backpressure and colliding writes
        lat_mode = 1'b0;
        for (int n = 0; n < 1500; n++) begin
            logic [63:0] b;
            logic [63:0] iv;
            logic [31:0] d;
            rng = nxt(rng); b  = {rng, rng ^ 32'hA5A5_0000};
            rng = nxt(rng); iv = (rng[3:0] == 4'd0) ? 64'd0 : {32'd0, rng};
            rng = nxt(rng);
            d = rng[1] ? {21'd0, rng[13:3]} : disp_pick(int'(rng[6:4]));
            set_req(rng[0] | rng[7], b, rng[8], rng[12:9], iv, rng[14:13], d);
            set_wr(rng[15] & rng[16], rng[20:17], rng[21]);
            out_ready = rng[22] | rng[23];
            tick();
        end
        out_ready = 1'b1;
        idle(10);

        // R8: every accepted request came out exactly once
        chk(rp == wp, "R8", "outstanding after drain", 64'(wp - rp), 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule